// File: doc/BRIEF.md
# DMA Data Width Adapter

This block sits inside a DMA channel between the read side and the write side. Each item read from the source has a width of byte, halfword or word. The adapter turns it into items of the configured destination width. The alignment mode selects what happens when the two widths differ. The block can zero-fill or sign-fill a narrow item. It can keep either the low or the high part of a wide item. In its third mode it combines several narrow items into one destination item, or splits one wide item into several.

Byte swaps can be applied to the source item. Byte and halfword swaps can be applied to the destination item. Both sides use a valid/ready handshake. The configuration inputs are static while items are in flight. Between configurations the channel drains. The output is registered. It holds steady under backpressure, and no item is lost, duplicated or reordered.

Top module: `dwa_adapter`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0. In_ready is 1 while the output register is empty.
- R2: The width codes are 0 for byte, 1 for halfword and 2 for word, and code 3 acts as word. With equal widths an item passes through unchanged apart from the exchanges. Input bits above the source width are ignored, and output bits above the destination width are always 0.
- R3: In alignment code 0 with a narrower source, the item is right-aligned and the upper bits are filled with zeros.
- R4: In alignment code 0 with a wider source, the low destination-width bits of the item are kept.
- R5: In alignment code 1 with a narrower source, the item is right-aligned and the upper bits are filled with copies of the source's top bit.
- R6: In alignment code 1 with a wider source, the high destination-width bits of the source item are kept, moved down to bit 0.
- R7: In alignment code 2 with a narrower source, dst/src consecutive items form one output item. The first item goes to the least significant position.
- R8: In alignment code 2 with a wider source, each item yields src/dst outputs, least significant part first. In_ready is 0 in the cycle after such an item is accepted.
- R9: Alignment code 3 behaves exactly like code 0.
- R10: The source byte swap applies only to a word source. It exchanges the two bytes of each halfword, so that source bytes [3,2,1,0] become [2,3,0,1]. For narrower sources it has no effect.
- R11: The destination byte swap exchanges the bytes inside each halfword when the destination is halfword or word. The destination halfword swap exchanges the two halves of a word destination. Together they reverse all four bytes. Neither swap has any effect on a destination too narrow for it.
- R12: While out_valid is 1 and out_ready is 0, out_data holds its value. Every expected item appears exactly once and in order.
- R13: Outside of splitting, an item accepted at a clock edge is on the output after that same edge. When splitting, the first part appears one edge later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_w | input | 2 | Source width code |
| cfg_dst_w | input | 2 | Destination width code |
| cfg_align | input | 2 | Alignment mode code |
| cfg_src_bswap | input | 1 | Source byte swap enable (word source only) |
| cfg_dst_bswap | input | 1 | Destination byte swap within halfwords |
| cfg_dst_hswap | input | 1 | Destination halfword swap within a word |
| in_valid | input | 1 | Source item valid |
| in_ready | output | 1 | Adapter accepts a source item |
| in_data | input | ITEM_W | Source item, right-aligned |
| out_valid | output | 1 | Destination item valid |
| out_ready | input | 1 | Destination accepts the item |
| out_data | output | ITEM_W | Destination item, right-aligned |

## Verification
In the pass-through, fill, truncate and combine modes, a result is due on the output right after the clock edge that accepts the completing input. When splitting, the first part arrives one edge later, and each further part needs one cycle with out_ready high. The bench drives its inputs at the falling edge. It samples in_ready, out_valid and out_data 1 ns later, well after settling and before the next rising edge. At that instant it compares a valid output with the head of a queue of expected items, and it removes the head only when out_ready is high. Directed checks also confirm that the output is empty, or already present, in the exact cycle where R13 places it.

// File: rtl/dwa_pkg.sv
`timescale 1ns/1ps
package dwa_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    WL_BYTE = 2'd0,
    WL_HALF = 2'd1,
    WL_WORD = 2'd2
  } width_log_e;

  localparam logic [1:0] ALIGN_EXT  = 2'd1;
  localparam logic [1:0] ALIGN_PACK = 2'd2;

  // fold the spare width code onto word
  function automatic logic [1:0] width_log(input logic [1:0] code);
    return (code == 2'd3) ? 2'(WL_WORD) : code;
  endfunction
endpackage

// File: rtl/dwa_xchg.sv
`timescale 1ns/1ps
module dwa_xchg #(
  parameter int ITEM_W = 32
) (
  input  logic [1:0]        wlog,
  input  logic              swap_b,
  input  logic              swap_h,
  input  logic [ITEM_W-1:0] din,
  output logic [ITEM_W-1:0] dout
);
  localparam int NL = ITEM_W / 8;

  logic [ITEM_W-1:0] bsw, stage1, hsw;

  generate
    for (genvar i = 0; i < NL; i++) begin : g_lane
      assign bsw[i*8 +: 8] = din[(i ^ 1)*8 +: 8];
      assign hsw[i*8 +: 8] = stage1[(i ^ 2)*8 +: 8];
    end
  endgenerate

  assign stage1 = (swap_b && wlog >= 2'd1) ? bsw : din;
  assign dout   = (swap_h && wlog >= 2'd2) ? hsw : stage1;
endmodule

// File: rtl/dwa_resize.sv
`timescale 1ns/1ps
module dwa_resize import dwa_pkg::*; #(
  parameter int ITEM_W = 32
) (
  input  logic [1:0]        sw_log,
  input  logic [1:0]        dw_log,
  input  logic              ext,
  input  logic [ITEM_W-1:0] din,
  output logic [ITEM_W-1:0] dout
);
  localparam int IW = $clog2(ITEM_W);

  logic [ITEM_W-1:0] smask, dmask, wide;
  logic [IW-1:0]     sidx;
  logic              sgn;

  always_comb begin
    smask = {ITEM_W{1'b1}} >> (ITEM_W - (LANE_W << sw_log));
    dmask = {ITEM_W{1'b1}} >> (ITEM_W - (LANE_W << dw_log));
    sidx  = IW'((LANE_W << sw_log) - 1);
    sgn   = din[sidx];
    wide  = din;
    if (sw_log < dw_log) begin
      if (ext && sgn) wide = din | ~smask;
    end else if (sw_log > dw_log) begin
      if (ext) wide = din >> ((LANE_W << sw_log) - (LANE_W << dw_log));
    end
    dout = wide & dmask;
  end
endmodule

// File: rtl/dwa_lanes.sv
`timescale 1ns/1ps
module dwa_lanes #(
  parameter int ITEM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sw_log,
  input  logic [1:0]        dw_log,
  input  logic              pack_en,
  input  logic              unpack_en,
  input  logic              in_valid,
  input  logic [ITEM_W-1:0] item,
  input  logic [ITEM_W-1:0] resized,
  input  logic              can_load,
  output logic              in_ready,
  output logic              emit,
  output logic [ITEM_W-1:0] emit_data
);
  localparam int IW = $clog2(ITEM_W);

  logic [1:0]        cnt, rlog, cnt_max;
  logic [ITEM_W-1:0] acc, hold, dmask, placed;
  logic              hold_v, last;
  logic [IW-1:0]     p_sh, u_sh;

  assign rlog    = pack_en ? (dw_log - sw_log) : (sw_log - dw_log);
  assign cnt_max = 2'((3'd1 << rlog) - 3'd1);
  assign last    = (cnt == cnt_max);
  assign p_sh    = IW'(cnt) << (3'(sw_log) + 3'd3);
  assign u_sh    = IW'(cnt) << (3'(dw_log) + 3'd3);
  assign dmask   = {ITEM_W{1'b1}} >> (ITEM_W - (8 << dw_log));
  assign placed  = item << p_sh;

  always_comb begin
    if (pack_en) begin
      in_ready  = !last || can_load;
      emit      = in_valid && last && can_load;
      emit_data = acc | placed;
    end else if (unpack_en) begin
      in_ready  = !hold_v || (last && can_load);
      emit      = hold_v && can_load;
      emit_data = (hold >> u_sh) & dmask;
    end else begin
      in_ready  = can_load;
      emit      = in_valid && can_load;
      emit_data = resized;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      acc    <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
    end else if (pack_en) begin
      if (in_valid && in_ready) begin
        if (last) begin
          acc <= '0;
          cnt <= '0;
        end else begin
          acc <= acc | placed;
          cnt <= cnt + 2'd1;
        end
      end
    end else if (unpack_en) begin
      if (emit) begin
        cnt <= last ? 2'd0 : cnt + 2'd1;
        if (last) hold_v <= 1'b0;
      end
      if (in_valid && in_ready) begin
        hold   <= item;
        hold_v <= 1'b1;
        cnt    <= '0;
      end
    end else begin
      cnt    <= '0;
      acc    <= '0;
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/dwa_adapter.sv
`timescale 1ns/1ps
module dwa_adapter import dwa_pkg::*; #(
  parameter int ITEM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_src_w,
  input  logic [1:0]        cfg_dst_w,
  input  logic [1:0]        cfg_align,
  input  logic              cfg_src_bswap,
  input  logic              cfg_dst_bswap,
  input  logic              cfg_dst_hswap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ITEM_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ITEM_W-1:0] out_data
);
  logic [1:0]        slog, dlog;
  logic              pack_en, unpack_en, can_load, emit, ext;
  logic [ITEM_W-1:0] smask, src_masked, src_item, resized, emit_data, dst_data;

  assign slog       = width_log(cfg_src_w);
  assign dlog       = width_log(cfg_dst_w);
  assign pack_en    = (cfg_align == ALIGN_PACK) && (slog < dlog);
  assign unpack_en  = (cfg_align == ALIGN_PACK) && (slog > dlog);
  assign ext        = (cfg_align == ALIGN_EXT);
  assign smask      = {ITEM_W{1'b1}} >> (ITEM_W - (LANE_W << slog));
  assign src_masked = in_data & smask;
  assign can_load   = !out_valid || out_ready;

  dwa_xchg #(.ITEM_W(ITEM_W)) u_src_xchg (
    .wlog   (slog),
    .swap_b (cfg_src_bswap && (slog == 2'(WL_WORD))),
    .swap_h (1'b0),
    .din    (src_masked),
    .dout   (src_item)
  );

  dwa_resize #(.ITEM_W(ITEM_W)) u_resize (
    .sw_log (slog),
    .dw_log (dlog),
    .ext    (ext),
    .din    (src_item),
    .dout   (resized)
  );

  dwa_lanes #(.ITEM_W(ITEM_W)) u_lanes (
    .clk       (clk),
    .rst       (rst),
    .sw_log    (slog),
    .dw_log    (dlog),
    .pack_en   (pack_en),
    .unpack_en (unpack_en),
    .in_valid  (in_valid),
    .item      (src_item),
    .resized   (resized),
    .can_load  (can_load),
    .in_ready  (in_ready),
    .emit      (emit),
    .emit_data (emit_data)
  );

  dwa_xchg #(.ITEM_W(ITEM_W)) u_dst_xchg (
    .wlog   (dlog),
    .swap_b (cfg_dst_bswap),
    .swap_h (cfg_dst_hswap),
    .din    (emit_data),
    .dout   (dst_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= dst_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dwa_checker.sv
`timescale 1ns/1ps
module dwa_checker #(
  parameter int ITEM_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_src_w,
  input logic [1:0]        cfg_dst_w,
  input logic [1:0]        cfg_align,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ITEM_W-1:0] out_data
);
  logic [1:0]        sl, dl;
  logic [ITEM_W-1:0] dm;
  logic              splitting;

  assign sl        = (cfg_src_w == 2'd3) ? 2'd2 : cfg_src_w;
  assign dl        = (cfg_dst_w == 2'd3) ? 2'd2 : cfg_dst_w;
  assign dm        = {ITEM_W{1'b1}} >> (ITEM_W - (8 << dl));
  assign splitting = (cfg_align == 2'd2) && (sl > dl);

  // R12: a stalled output neither drops nor changes
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2: nothing above the destination width
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data & ~dm) == '0));

  // R13: non-splitting acceptance shows on the output after the edge
  a_r13_next_cycle: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !splitting && !(cfg_align == 2'd2 && sl < dl) |=> out_valid);

  // R8: a freshly held wide item blocks the input
  a_r8_split_busy: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && splitting |=> !in_ready);
endmodule

bind dwa_adapter dwa_checker #(.ITEM_W(ITEM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_src_w (cfg_src_w),
  .cfg_dst_w (cfg_dst_w),
  .cfg_align (cfg_align),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_dwa_adapter.sv
`timescale 1ns/1ps
module test_dwa_adapter;
  localparam int ITEM_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0]  cfg_src_w = 2'd2, cfg_dst_w = 2'd2, cfg_align = 2'd0;
  logic        cfg_src_bswap = 1'b0, cfg_dst_bswap = 1'b0, cfg_dst_hswap = 1'b0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] in_data = '0, out_data;

  dwa_adapter #(.ITEM_W(ITEM_W)) i_dwa_adapter (
    .clk(clk), .rst(rst), .cfg_src_w(cfg_src_w), .cfg_dst_w(cfg_dst_w),
    .cfg_align(cfg_align), .cfg_src_bswap(cfg_src_bswap),
    .cfg_dst_bswap(cfg_dst_bswap), .cfg_dst_hswap(cfg_dst_hswap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  bit done = 0, bp_en = 0, gap_en = 0;
  string cur_tag = "R1";
  logic [31:0] expq[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : ((c == 2'd1) ? 2 : 4);
  endfunction

  function automatic logic [31:0] bmask(input int nb);
    return (nb >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
  endfunction

  function automatic logic [31:0] dst_swap(input logic [31:0] v, input int db);
    logic [31:0] r = v;
    if (cfg_dst_bswap && db >= 2) r = {r[23:16], r[31:24], r[7:0], r[15:8]};
    if (cfg_dst_hswap && db == 4) r = {r[15:0], r[31:16]};
    return r;
  endfunction

  // behavioural model: turns a list of source items into expected outputs
  task automatic model(input logic [31:0] items[$]);
    int sb = bytes_of(cfg_src_w);
    int db = bytes_of(cfg_dst_w);
    int k = 0;
    logic [31:0] v, acc = '0;
    foreach (items[i]) begin
      v = items[i];
      if (cfg_src_bswap && sb == 4) v = {v[23:16], v[31:24], v[7:0], v[15:8]};
      v = v & bmask(sb);
      if (cfg_align == 2'd2 && sb < db) begin
        acc = acc | (v << (8 * sb * k));
        k++;
        if (k == db / sb) begin
          expq.push_back(dst_swap(acc, db));
          acc = '0;
          k = 0;
        end
      end else if (cfg_align == 2'd2 && sb > db) begin
        for (int j = 0; j < sb / db; j++)
          expq.push_back(dst_swap((v >> (8 * db * j)) & bmask(db), db));
      end else begin
        if (sb < db && cfg_align == 2'd1 && v[8*sb-1]) v = v | ~bmask(sb);
        if (sb > db && cfg_align == 2'd1) v = v >> (8 * (sb - db));
        expq.push_back(dst_swap(v & bmask(db), db));
      end
    end
  endtask

  // output side: random backpressure, compare with queue head every cycle
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (!rst && out_valid) begin
        if (expq.size() == 0) check(1'b0, {cur_tag, " R12 unexpected item"}, out_data, 32'h0);
        else begin
          check(out_data === expq[0], {cur_tag, " R12 data"}, out_data, expq[0]);
          if (out_ready) void'(expq.pop_front());
        end
      end
    end
  end

  task automatic send(input logic [31:0] items[$]);
    foreach (items[i]) begin
      bit taken = 0;
      while (!taken) begin
        @(negedge clk);
        if (gap_en && ($urandom % 3) == 0) in_valid = 1'b0;
        else begin
          in_valid = 1'b1;
          in_data  = items[i];
          #1;
          taken = in_ready;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (expq.size() != 0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(expq.size() == 0, {tag, " R12 all items delivered"}, 32'(expq.size()), 32'h0);
  endtask

  task automatic mk(output logic [31:0] q[$]);
    q = '{32'h0000_0080, 32'hFFFF_7F7F, 32'h8001_A5C3, 32'h1234_5678};
    repeat (4) q.push_back($urandom);
  endtask

  task automatic run_case(input string tag, input logic [1:0] s, input logic [1:0] d,
                          input logic [1:0] al, input logic sbx, input logic dbx, input logic dhx);
    logic [31:0] q[$];
    @(negedge clk);
    cfg_src_w = s; cfg_dst_w = d; cfg_align = al;
    cfg_src_bswap = sbx; cfg_dst_bswap = dbx; cfg_dst_hswap = dhx;
    cur_tag = tag;
    mk(q);
    model(q);
    send(q);
    drain(tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
    rst = 1'b0;
    #1;
    check(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
    check(in_ready === 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);

    // R13 directed timing with free output
    bp_en = 0; gap_en = 0;
    @(negedge clk);
    cur_tag = "R13 pass";
    in_valid = 1'b1; in_data = 32'hCAFE_0001; expq.push_back(32'hCAFE_0001);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid === 1'b1, "R13 one edge after acceptance", 32'(out_valid), 32'h1);
    drain("R13 pass");
    @(negedge clk);
    cfg_src_w = 2'd2; cfg_dst_w = 2'd0; cfg_align = 2'd2; cur_tag = "R13 split";
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h4433_2211;
    expq.push_back(32'h11); expq.push_back(32'h22); expq.push_back(32'h33); expq.push_back(32'h44);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid === 1'b0, "R13 split not yet out", 32'(out_valid), 32'h0);
    check(in_ready === 1'b0, "R8 input blocked while splitting", 32'(in_ready), 32'h0);
    @(negedge clk);
    #1;
    check(out_valid === 1'b1 && out_data === 32'h11, "R13 R8 first split part", out_data, 32'h11);
    drain("R13 split");

    // directed sign fill value
    @(negedge clk);
    cfg_src_w = 2'd0; cfg_dst_w = 2'd2; cfg_align = 2'd1; cur_tag = "R5 directed";
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h1234_5680; expq.push_back(32'hFFFF_FF80);
    @(negedge clk);
    in_valid = 1'b0;
    drain("R5 directed");

    bp_en = 1; gap_en = 1;
    for (int pass = 0; pass < 2; pass++) begin
      run_case("R2 word pass",        2'd2, 2'd2, 2'd0, 0, 0, 0);
      run_case("R2 byte pass",        2'd0, 2'd0, 2'd0, 0, 0, 0);
      run_case("R2 half pass",        2'd1, 2'd1, 2'd1, 0, 0, 0);
      run_case("R2 code3 as word",    2'd3, 2'd3, 2'd2, 0, 0, 0);
      run_case("R3 byte to word",     2'd0, 2'd2, 2'd0, 0, 0, 0);
      run_case("R3 half to word",     2'd1, 2'd2, 2'd0, 0, 0, 0);
      run_case("R3 byte to half",     2'd0, 2'd1, 2'd0, 0, 0, 0);
      run_case("R4 word to byte",     2'd2, 2'd0, 2'd0, 0, 0, 0);
      run_case("R4 word to half",     2'd2, 2'd1, 2'd0, 0, 0, 0);
      run_case("R4 half to byte",     2'd1, 2'd0, 2'd0, 0, 0, 0);
      run_case("R5 byte to word",     2'd0, 2'd2, 2'd1, 0, 0, 0);
      run_case("R5 half to word",     2'd1, 2'd2, 2'd1, 0, 0, 0);
      run_case("R5 byte to half",     2'd0, 2'd1, 2'd1, 0, 0, 0);
      run_case("R6 word to byte",     2'd2, 2'd0, 2'd1, 0, 0, 0);
      run_case("R6 word to half",     2'd2, 2'd1, 2'd1, 0, 0, 0);
      run_case("R6 half to byte",     2'd1, 2'd0, 2'd1, 0, 0, 0);
      run_case("R7 bytes to word",    2'd0, 2'd2, 2'd2, 0, 0, 0);
      run_case("R7 halves to word",   2'd1, 2'd2, 2'd2, 0, 0, 0);
      run_case("R7 bytes to half",    2'd0, 2'd1, 2'd2, 0, 0, 0);
      run_case("R8 word to bytes",    2'd2, 2'd0, 2'd2, 0, 0, 0);
      run_case("R8 word to halves",   2'd2, 2'd1, 2'd2, 0, 0, 0);
      run_case("R8 half to bytes",    2'd1, 2'd0, 2'd2, 0, 0, 0);
      run_case("R9 code3 widen",      2'd0, 2'd2, 2'd3, 0, 0, 0);
      run_case("R9 code3 narrow",     2'd2, 2'd1, 2'd3, 0, 0, 0);
      run_case("R10 word src swap",   2'd2, 2'd2, 2'd0, 1, 0, 0);
      run_case("R10 half src ignore", 2'd1, 2'd1, 2'd0, 1, 0, 0);
      run_case("R10 swap then split", 2'd2, 2'd0, 2'd2, 1, 0, 0);
      run_case("R11 word byte swap",  2'd2, 2'd2, 2'd0, 0, 1, 0);
      run_case("R11 word half swap",  2'd2, 2'd2, 2'd0, 0, 0, 1);
      run_case("R11 word reverse",    2'd2, 2'd2, 2'd0, 0, 1, 1);
      run_case("R11 half byte swap",  2'd1, 2'd1, 2'd0, 0, 1, 0);
      run_case("R11 byte ignore",     2'd0, 2'd0, 2'd0, 0, 1, 1);
      run_case("R11 half hswap none", 2'd1, 2'd1, 2'd0, 0, 0, 1);
      run_case("R11 pack reverse",    2'd0, 2'd2, 2'd2, 0, 1, 1);
      gap_en = 0;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule